// File: doc/BRIEF.md
# Boot-Time Interrupt Pin Gate

This block sits between four external interrupt request lines and the four interrupt input pins of a processor. It holds the processor in a start-up configuration until the processor shows that its own boot code has finished. Once that happens, the block gets out of the way and hands the pins to the external interrupt sources.

After a board-level reset the block is in boot mode. In that mode each processor interrupt pin carries the level of a static boot-code bit, and the external lines are shut out completely. Edges that arrive on the external lines in boot mode are dropped, not stored. When the processor issues an interrupt-acknowledge pulse, the block synchronises and edge-detects it and changes to run mode. Run mode lasts until the next reset. In run mode each pin follows its external line through logic only, so the falling edges the processor reacts to reach it with no clock delay. Only one source drives a given pin at any time. A status output reports which mode the block is in.

Top module: `irqgate_top`

## Requirements
- R1: While rst_n is low at a rising clock edge, and after that edge, the block is in boot mode and boot_mode_o reads 1.
- R2: In boot mode, every bit of irq_o equals the matching bit of boot_code_i, whatever the value of ext_irq_i.
- R3: External edges seen in boot mode are discarded. Right after the change to run mode, irq_o equals the present level of ext_irq_i, and no pulse is left over from earlier activity.
- R4: The acknowledge input ack_i is active high and must be high for at least one clock period. With the default two synchroniser stages, boot_mode_o changes to 0 on the third rising clock edge after ack_i rises, and not earlier.
- R5: In run mode, every bit of irq_o equals the matching bit of ext_irq_i within the same cycle, with no clock delay.
- R6: In run mode, further acknowledge pulses have no effect: boot_mode_o stays 0 and irq_o keeps following ext_irq_i.
- R7: An acknowledge held high for many cycles causes exactly one mode change.
- R8: Activity on ext_irq_i or boot_code_i never changes the mode; in boot mode only ack_i leaves boot mode.
- R9: A reset taken while in run mode returns the block to boot mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor-side clock |
| rst_n | input | 1 | Synchronous active-low board reset |
| ack_i | input | 1 | Interrupt-acknowledge pulse from the processor, active high |
| ext_irq_i | input | 4 | External interrupt request lines, push-pull, falling-edge sensitive |
| boot_code_i | input | 4 | Static boot-configuration levels for the interrupt pins |
| irq_o | output | 4 | Processor interrupt input pins |
| boot_mode_o | output | 1 | 1 in boot mode, 0 in run mode |

## Verification
The assertions assume that ack_i is a clean level that stays high for at least one clock period. They also assume that boot_code_i and ext_irq_i settle between clock edges, because the pin comparisons are sampled at the edge. The stimulus changes every input one time unit after a rising edge and holds it for a full period or longer, so it keeps within these assumptions. The sweeps cover all 256 pairs of boot code and external value in boot mode, and every external value in run mode.

// File: rtl/irqgate_pkg.sv
// Shared types for the boot-time interrupt pin gate.
// Assumes: nothing beyond IEEE 1800-2017.
package irqgate_pkg;

    // Operating mode; the encoding is the value seen on the status output.
    typedef enum logic {
        MODE_RUN  = 1'b0,
        MODE_BOOT = 1'b1
    } irq_mode_e;

endpackage

// File: rtl/irqgate_ack_sync.sv
// Acknowledge synchroniser and rising-edge detector.
// Shifts the asynchronous acknowledge through SYNC_STAGES flops, then
// emits a single-cycle pulse when the synchronised level rises.
// Assumes: SYNC_STAGES >= 2, and the acknowledge stays high for at least
// one clock period.
module irqgate_ack_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_i,
    output logic ack_edge_o
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] sync_q;
    logic         last_q;

    // Shift the raw acknowledge through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[MSB-1:0], ack_i};
    end

    // Remember the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[MSB];
    end

    // One-cycle pulse on a rising synchronised level.
    always_comb ack_edge_o = sync_q[MSB] & ~last_q;

endmodule

// File: rtl/irqgate_mode_ctrl.sv
// Mode flip-flop. Reset sets boot mode, and only an acknowledge edge
// clears it to run mode. Run mode is sticky until the next reset.
// Assumes: ack_edge_i is a single-cycle pulse in the clk domain.
module irqgate_mode_ctrl
    import irqgate_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ack_edge_i,
    output irq_mode_e mode_o
);
    irq_mode_e mode_q;

    // Hold the mode; one-way change from boot to run.
    always_ff @(posedge clk) begin
        if (!rst_n)                              mode_q <= MODE_BOOT;
        else if (ack_edge_i && mode_q == MODE_BOOT) mode_q <= MODE_RUN;
    end

    // Drive the registered mode out.
    always_comb mode_o = mode_q;

endmodule

// File: rtl/irqgate_pin_mux.sv
// Per-pin selector: boot-code level in boot mode, live external line in
// run mode. Purely combinational, so nothing is stored and the external
// falling edges pass with no clock delay.
// Assumes: mode_i is glitch-free (it comes straight from a flop).
module irqgate_pin_mux
    import irqgate_pkg::*;
#(
    parameter int N_IRQ = 4
) (
    input  irq_mode_e          mode_i,
    input  logic [N_IRQ-1:0]   ext_irq_i,
    input  logic [N_IRQ-1:0]   boot_code_i,
    output logic [N_IRQ-1:0]   irq_o
);
    for (genvar g = 0; g < N_IRQ; g++) begin : g_lane
        // Exactly one source drives each pin at a time.
        always_comb irq_o[g] = (mode_i == MODE_BOOT) ? boot_code_i[g] : ext_irq_i[g];
    end

endmodule

// File: rtl/irqgate_top.sv
// Boot-time interrupt pin gate: holds the processor interrupt pins at
// boot-configuration levels until an acknowledge pulse, then passes the
// external interrupt lines through for good.
// Assumes: synchronous active-low reset; acknowledge held >= 1 clock.
module irqgate_top
    import irqgate_pkg::*;
#(
    parameter int N_IRQ       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack_i,
    input  logic [N_IRQ-1:0] ext_irq_i,
    input  logic [N_IRQ-1:0] boot_code_i,
    output logic [N_IRQ-1:0] irq_o,
    output logic             boot_mode_o
);
    logic      ack_edge;
    irq_mode_e mode;

    irqgate_ack_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .ack_i      (ack_i),
        .ack_edge_o (ack_edge)
    );

    irqgate_mode_ctrl u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .ack_edge_i (ack_edge),
        .mode_o     (mode)
    );

    irqgate_pin_mux #(.N_IRQ(N_IRQ)) u_mux (
        .mode_i      (mode),
        .ext_irq_i   (ext_irq_i),
        .boot_code_i (boot_code_i),
        .irq_o       (irq_o)
    );

    // Report the mode on the status pin.
    always_comb boot_mode_o = (mode == MODE_BOOT);

endmodule

// File: rtl/irqgate_chk.sv
// Checker for the boot-time interrupt pin gate, bound to irqgate_top.
module irqgate_chk #(
    parameter int N_IRQ = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ack_edge,
    input logic [N_IRQ-1:0] ext_irq_i,
    input logic [N_IRQ-1:0] boot_code_i,
    input logic [N_IRQ-1:0] irq_o,
    input logic             boot_mode_o
);
    // R1
    reset_boot_chk: assert property (@(posedge clk) !rst_n |=> boot_mode_o);

    // R2
    boot_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boot_mode_o |-> (irq_o == boot_code_i));

    // R5
    run_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !boot_mode_o |-> (irq_o == ext_irq_i));

    // R6
    run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !boot_mode_o |=> !boot_mode_o);

    // R8
    leave_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_mode_o && !ack_edge) |=> boot_mode_o);

    // R7
    single_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_edge |=> !ack_edge);

endmodule

bind irqgate_top irqgate_chk #(.N_IRQ(N_IRQ)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_edge    (ack_edge),
    .ext_irq_i   (ext_irq_i),
    .boot_code_i (boot_code_i),
    .irq_o       (irq_o),
    .boot_mode_o (boot_mode_o)
);

// File: tb/irqgate_top_tb_top.sv
`timescale 1ns/1ps
module irqgate_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ack_i = 1'b0;
    logic [3:0] ext_irq_i = 4'h0;
    logic [3:0] boot_code_i = 4'h0;
    logic [3:0] irq_o;
    logic       boot_mode_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    irqgate_top dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ack_i       (ack_i),
        .ext_irq_i   (ext_irq_i),
        .boot_code_i (boot_code_i),
        .irq_o       (irq_o),
        .boot_mode_o (boot_mode_o)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step();
        chk("R1 status during reset", 32'(boot_mode_o), 32'd1);
        step();
        rst_n = 1'b1;
    endtask

    // Single-cycle acknowledge; mode changes on the 3rd edge after it rises.
    task automatic pulse_ack_and_check_timing(input string req);
        ack_i = 1'b1;
        step();
        ack_i = 1'b0;
        chk({req, " still boot after 1 edge"}, 32'(boot_mode_o), 32'd1);
        step();
        chk({req, " still boot after 2 edges"}, 32'(boot_mode_o), 32'd1);
        step();
        chk({req, " run after 3 edges"}, 32'(boot_mode_o), 32'd0);
    endtask

    initial begin
        int wd = 0;
        while (!done && wd < 20000) begin
            @(posedge clk);
            wd++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected done", wd);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        chk("R1 status after reset", 32'(boot_mode_o), 32'd1);

        // R2, R8: full sweep of boot code x external value in boot mode.
        for (int b = 0; b < 16; b++) begin
            for (int e = 0; e < 16; e++) begin
                boot_code_i = 4'(b);
                ext_irq_i   = 4'(e);
                step();
                chk("R2 boot pins", 32'(irq_o), 32'(b));
                chk("R8 no mode change from pins", 32'(boot_mode_o), 32'd1);
            end
        end

        // R3: falling edges in boot mode, then change mode with lines high.
        boot_code_i = 4'h5;
        for (int k = 0; k < 4; k++) begin
            ext_irq_i = 4'h0; step();
            ext_irq_i = 4'hF; step();
        end
        pulse_ack_and_check_timing("R4");
        chk("R3 no leftover pulse after change", 32'(irq_o), 32'hF);
        #1;
        chk("R3 still idle", 32'(irq_o), 32'hF);

        // R5: run-mode sweep, checked combinationally mid-cycle.
        for (int b = 0; b < 16; b += 5) begin
            for (int e = 0; e < 16; e++) begin
                boot_code_i = 4'(b);
                ext_irq_i   = 4'(e);
                #0.5;
                chk("R5 run pins same cycle", 32'(irq_o), 32'(e));
                step();
                chk("R5 run pins after edge", 32'(irq_o), 32'(e));
            end
        end

        // R6: further acknowledges have no effect.
        for (int k = 0; k < 3; k++) begin
            ack_i = 1'b1; step();
            ack_i = 1'b0;
            for (int j = 0; j < 4; j++) begin
                ext_irq_i = 4'(j * 3 + k);
                step();
                chk("R6 stays run", 32'(boot_mode_o), 32'd0);
                chk("R6 pins follow ext", 32'(irq_o), 32'(j * 3 + k));
            end
        end

        // R9: reset from run mode returns to boot.
        boot_code_i = 4'hA;
        ext_irq_i   = 4'h3;
        do_reset();
        chk("R9 boot after reset", 32'(boot_mode_o), 32'd1);
        chk("R9 pins show boot code", 32'(irq_o), 32'hA);

        // R7: long acknowledge gives one change, mode then sticks.
        ack_i = 1'b1;
        step();
        chk("R7 boot after 1 edge", 32'(boot_mode_o), 32'd1);
        step();
        chk("R7 boot after 2 edges", 32'(boot_mode_o), 32'd1);
        step();
        chk("R7 run after 3 edges", 32'(boot_mode_o), 32'd0);
        for (int k = 0; k < 10; k++) begin
            step();
            chk("R7 run while ack held", 32'(boot_mode_o), 32'd0);
        end
        ack_i = 1'b0;
        for (int k = 0; k < 4; k++) begin
            step();
            chk("R7 run after ack drops", 32'(boot_mode_o), 32'd0);
        end
        chk("R5 pins follow ext after long ack", 32'(irq_o), 32'h3);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule